// File: doc/BRIEF.md
# Station Address Table Loader

This block fills a sixteen-entry table of 48-bit station addresses from a list of descriptors in system memory. Software places descriptors in memory and programs a descriptor pointer and a descriptor count. It then sets a load command bit. The sequencer reads one 16-bit field per memory request and writes each address word into the entry that the descriptor names. After every descriptor it moves the pointer forward and decrements the count. When the count reaches zero it reads one more field at the pointer, which becomes the 16-bit entry-enable mask. It then clears the command bit and raises a sticky completion flag.

The memory port issues one request at a time with a valid/ready handshake and waits for a response strobe before it uses the returned data. Two configuration inputs control how fields are read. One selects a 16-bit or 32-bit bus, which sets the spacing of fields in memory. The other selects big-endian or little-endian byte order. A small register port lets software program the loader and read stored entries back. Entries can be read back only while a software-reset bit is held.

Top module: `addr_table_loader`

## Requirements
- R1: After reset, the command register reads 0, the status register (offset 9) reads 0, `irq` is low, the enable mask reads 0, no memory request is valid, and every table word reads 0.
- R2: A load processes as many descriptors as the count register (offset 3, bits 4:0) holds. Each descriptor is four fields. In field 0, bits 3:0 select the entry and bits 15:4 are ignored. Fields 1, 2 and 3 become words 0, 1 and 2 of that entry.
- R3: Field k of a descriptor is read at pointer + 2k with `cfg_wide`=0, or at pointer + 4k with `cfg_wide`=1. After each descriptor the count drops by one and the pointer (offsets 1 and 2, low half and high half) rises by 8 or 16 bytes.
- R4: Once the count is zero, one more field is read at the current pointer, and its value is stored as the enable mask (offset 8). A load that starts with a count of 0 makes only this single request and leaves the pointer unchanged.
- R5: With `cfg_wide`=1, only the low 16-bit half of each 32-bit word is used. The other half has no effect on any stored value.
- R6: With `cfg_big_endian`=0, the byte at the lower address is the low-order byte of a field. With `cfg_big_endian`=1, it is the high-order byte. With `cfg_wide`=1, the low half of a big-endian word is the pair of bytes at offsets 2 and 3.
- R7: Offsets 5, 6 and 7 return words 0, 1 and 2 of the entry selected by bits 3:0 of offset 4, but only while command bit 1 (software reset) is 1. Otherwise they read 0.
- R8: Writing 1 to command bit 0 starts a load, and the bit reads 1 until the load finishes. On completion the sequencer clears the bit and sets status bit 0, which drives `irq`. Writing 1 to status bit 0 clears it, and writing 0 has no effect.
- R9: A request stays valid with a stable address until it is accepted. No new request is issued until the response to the previous one arrives, and no request is issued while no load is pending.
- R10: If load completion and a software write of 1 to status bit 0 fall in the same cycle, the status bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects the 32-bit bus mode |
| cfg_big_endian | input | 1 | 1 selects big-endian byte order |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Sticky load-done flag |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the field |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Raw bytes; the lowest address sits in bits 7:0 |

## Verification
Load completion and a software clear of the done flag can land on the same clock edge. The intended result is that the flag stays set, because the new completion must not be lost. The bench provokes this case with a hand-timed memory responder. It watches for the response to the mask read to go out, then drives a write-1-to-clear of the status register so that it is sampled on the same edge as that response. It then judges the outcome: `irq` and the status bit must read 1, the load bit must read 0, and the mask must hold the new value. The other requirements are covered by loads in both bus widths and both byte orders, with junk in the ignored bits and a stalling ready signal.

// File: rtl/atl_pkg.sv
package atl_pkg;

    localparam int ADDR_W  = 32;
    localparam int FW      = 16;
    localparam int DATA_W  = 32;
    localparam int ENTRY_N = 16;
    localparam int WORDS   = 3;
    localparam int CNT_W   = 5;
    localparam int IDX_W   = $clog2(ENTRY_N);
    localparam int SEL_W   = $clog2(WORDS);
    localparam int REG_AW  = 4;
    localparam int OFF_W   = 6;

    localparam logic [REG_AW-1:0] RA_CMD    = 4'd0;
    localparam logic [REG_AW-1:0] RA_PTR_LO = 4'd1;
    localparam logic [REG_AW-1:0] RA_PTR_HI = 4'd2;
    localparam logic [REG_AW-1:0] RA_COUNT  = 4'd3;
    localparam logic [REG_AW-1:0] RA_SEL    = 4'd4;
    localparam logic [REG_AW-1:0] RA_ENT0   = 4'd5;
    localparam logic [REG_AW-1:0] RA_ENT1   = 4'd6;
    localparam logic [REG_AW-1:0] RA_ENT2   = 4'd7;
    localparam logic [REG_AW-1:0] RA_MASK   = 4'd8;
    localparam logic [REG_AW-1:0] RA_STAT   = 4'd9;

    localparam int CMD_LOAD_BIT = 0;
    localparam int CMD_SRST_BIT = 1;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT
    } seq_state_e;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] word;
        logic [FW-1:0]    data;
    } tbl_wr_t;

    // Byte offset of field number idx for the selected bus width.
    function automatic logic [OFF_W-1:0] field_offset(logic [2:0] idx, logic wide);
        return wide ? {1'b0, idx, 2'b00} : {2'b00, idx, 1'b0};
    endfunction

    // Extract the 16-bit field from the raw response bytes.
    function automatic logic [FW-1:0] pick_half(logic [DATA_W-1:0] d, logic wide, logic be);
        if (!wide)
            return be ? {d[7:0], d[15:8]} : d[15:0];
        else
            return be ? {d[23:16], d[31:24]} : d[15:0];
    endfunction

endpackage

// File: rtl/atl_seq.sv
module atl_seq
    import atl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wide,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output tbl_wr_t           tbl_wr,
    output logic              step,
    output logic              done,
    output logic [FW-1:0]     field_val
);

    seq_state_e       state;
    logic [1:0]       fld;
    logic             is_mask_q;
    logic [IDX_W-1:0] idx_q;
    logic             rsp_hit;

    always_comb begin
        field_val     = pick_half(mem_rsp_data, wide, big_endian);
        rsp_hit       = (state == S_WAIT) && mem_rsp_valid;
        mem_req_valid = (state == S_REQ);
        mem_req_addr  = cur_ptr + {{(ADDR_W-OFF_W){1'b0}}, field_offset({1'b0, fld}, wide)};
        tbl_wr.we     = rsp_hit && !is_mask_q && (fld != 2'd0);
        tbl_wr.idx    = idx_q;
        tbl_wr.word   = SEL_W'(fld - 2'd1);
        tbl_wr.data   = field_val;
        step          = rsp_hit && !is_mask_q && (fld == 2'd3);
        done          = rsp_hit && is_mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            fld       <= 2'd0;
            is_mask_q <= 1'b0;
            idx_q     <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_REQ;
                        fld   <= 2'd0;
                    end
                end
                S_REQ: begin
                    if (mem_req_ready) begin
                        state     <= S_WAIT;
                        is_mask_q <= (cur_cnt == '0);
                    end
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (is_mask_q) begin
                            state <= S_IDLE;
                        end else begin
                            if (fld == 2'd0) idx_q <= field_val[IDX_W-1:0];
                            fld   <= fld + 2'd1;
                            state <= S_REQ;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/atl_table.sv
module atl_table #(
    parameter int ENTRIES = 16,
    parameter int NWORDS  = 3,
    parameter int W       = 16,
    localparam int IW     = $clog2(ENTRIES),
    localparam int SW     = $clog2(NWORDS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IW-1:0]              widx,
    input  logic [SW-1:0]              wsel,
    input  logic [W-1:0]               wdata,
    input  logic [IW-1:0]              ridx,
    output logic [NWORDS-1:0][W-1:0]   rwords
);

    logic [NWORDS-1:0][W-1:0] store [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst)
                    store[e][w] <= '0;
                else if (we && widx == IW'(e) && wsel == SW'(w))
                    store[e][w] <= wdata;
            end
        end
    end

    assign rwords = store[ridx];

endmodule

// File: rtl/atl_readback.sv
module atl_readback
    import atl_pkg::*;
(
    input  logic [REG_AW-1:0]        addr,
    input  logic                     cmd_load,
    input  logic                     cmd_srst,
    input  logic [ADDR_W-1:0]        ptr,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [IDX_W-1:0]         sel,
    input  logic [FW-1:0]            mask,
    input  logic                     done_flag,
    input  logic [WORDS-1:0][FW-1:0] words,
    output logic [FW-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CMD:    begin
                rdata[CMD_LOAD_BIT] = cmd_load;
                rdata[CMD_SRST_BIT] = cmd_srst;
            end
            RA_PTR_LO: rdata = ptr[FW-1:0];
            RA_PTR_HI: rdata = ptr[ADDR_W-1:FW];
            RA_COUNT:  rdata = FW'(cnt);
            RA_SEL:    rdata = FW'(sel);
            RA_ENT0:   rdata = cmd_srst ? words[0] : '0;
            RA_ENT1:   rdata = cmd_srst ? words[1] : '0;
            RA_ENT2:   rdata = cmd_srst ? words[2] : '0;
            RA_MASK:   rdata = mask;
            RA_STAT:   rdata = FW'(done_flag);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/addr_table_loader.sv
module addr_table_loader
    import atl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              cfg_big_endian,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [FW-1:0]     reg_wdata,
    output logic [FW-1:0]     reg_rdata,
    output logic              irq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic                     cmd_load, cmd_srst, done_flag;
    logic [ADDR_W-1:0]        ptr_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [IDX_W-1:0]         sel_q;
    logic [FW-1:0]            mask_q;
    tbl_wr_t                  tbl_wr;
    logic                     seq_step, seq_done;
    logic [FW-1:0]            field_val;
    logic [WORDS-1:0][FW-1:0] ent_words;
    logic [ADDR_W-1:0]        stride;
    logic                     cfg_wr;

    assign stride = {{(ADDR_W-OFF_W){1'b0}}, field_offset(3'd4, cfg_wide)};
    assign cfg_wr = reg_we && !cmd_load;

    atl_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (cmd_load),
        .wide          (cfg_wide),
        .big_endian    (cfg_big_endian),
        .cur_ptr       (ptr_q),
        .cur_cnt       (cnt_q),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tbl_wr        (tbl_wr),
        .step          (seq_step),
        .done          (seq_done),
        .field_val     (field_val)
    );

    atl_table #(.ENTRIES(ENTRY_N), .NWORDS(WORDS), .W(FW)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_wr.we),
        .widx   (tbl_wr.idx),
        .wsel   (tbl_wr.word),
        .wdata  (tbl_wr.data),
        .ridx   (sel_q),
        .rwords (ent_words)
    );

    atl_readback u_rb (
        .addr      (reg_addr),
        .cmd_load  (cmd_load),
        .cmd_srst  (cmd_srst),
        .ptr       (ptr_q),
        .cnt       (cnt_q),
        .sel       (sel_q),
        .mask      (mask_q),
        .done_flag (done_flag),
        .words     (ent_words),
        .rdata     (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_load  <= 1'b0;
            cmd_srst  <= 1'b0;
            done_flag <= 1'b0;
            ptr_q     <= '0;
            cnt_q     <= '0;
            sel_q     <= '0;
            mask_q    <= '0;
        end else begin
            // command register
            if (seq_done)
                cmd_load <= 1'b0;
            else if (reg_we && reg_addr == RA_CMD && reg_wdata[CMD_LOAD_BIT])
                cmd_load <= 1'b1;
            if (reg_we && reg_addr == RA_CMD)
                cmd_srst <= reg_wdata[CMD_SRST_BIT];

            // pointer and count: sequencer owns them while a load is pending
            if (seq_step) begin
                ptr_q <= ptr_q + stride;
                cnt_q <= cnt_q - 1'b1;
            end else if (cfg_wr) begin
                if (reg_addr == RA_PTR_LO) ptr_q[FW-1:0]     <= reg_wdata;
                if (reg_addr == RA_PTR_HI) ptr_q[ADDR_W-1:FW] <= reg_wdata;
                if (reg_addr == RA_COUNT)  cnt_q             <= reg_wdata[CNT_W-1:0];
            end

            if (reg_we && reg_addr == RA_SEL)
                sel_q <= reg_wdata[IDX_W-1:0];

            if (seq_done)
                mask_q <= field_val;

            // sticky completion flag, set has priority over clear
            if (seq_done)
                done_flag <= 1'b1;
            else if (reg_we && reg_addr == RA_STAT && reg_wdata[0])
                done_flag <= 1'b0;
        end
    end

    assign irq = done_flag;

endmodule

// File: rtl/atl_checker.sv
module atl_checker
    import atl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              irq,
    input logic              cmd_load,
    input logic              cmd_srst,
    input logic [CNT_W-1:0]  cnt,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [FW-1:0]     reg_rdata,
    input logic              done
);

    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (mem_req_valid && mem_req_ready)
            pending <= 1'b1;
        else if (mem_rsp_valid)
            pending <= 1'b0;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        pending |-> !mem_req_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cmd_load |-> !mem_req_valid); // R9
    AST_DONE_CLEARS_LOAD: assert property (@(posedge clk) disable iff (rst)
        done |=> !cmd_load); // R8
    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        done |=> irq); // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) && !($past(reg_we) && $past(reg_addr) == RA_COUNT)
        |-> cnt == $past(cnt) - 5'd1); // R3
    AST_READBACK_GATED: assert property (@(posedge clk) disable iff (rst)
        !cmd_srst && (reg_addr == RA_ENT0 || reg_addr == RA_ENT1 || reg_addr == RA_ENT2)
        |-> reg_rdata == '0); // R7

endmodule

bind addr_table_loader atl_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .irq           (irq),
    .cmd_load      (cmd_load),
    .cmd_srst      (cmd_srst),
    .cnt           (cnt_q),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .done          (seq_done)
);

// File: tb/addr_table_loader_bench.sv
`timescale 1ns/1ps
module addr_table_loader_bench;
    import atl_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wide = 1'b0, cfg_be = 1'b0;
    logic              reg_we = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [FW-1:0]     reg_wdata = '0;
    logic [FW-1:0]     reg_rdata;
    logic              irq;
    logic              mem_req_valid, mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    int checks = 0, failures = 0, req_count = 0, rsp_cnt = 0;
    logic              stall = 1'b0;
    logic [ADDR_W-1:0] pend_addr = '0;
    logic [7:0]        mem [0:1023];
    logic [FW-1:0]     exp_tbl [ENTRY_N][WORDS];
    logic [FW-1:0]     rd;

    always #4 clk = ~clk;

    addr_table_loader u_addr_table_loader (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_big_endian(cfg_be),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] mem_word(logic [ADDR_W-1:0] a);
        logic [9:0] b = a[9:0];
        if (cfg_wide) return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
        return {16'h0, mem[b+1], mem[b]};
    endfunction

    // memory responder: two-cycle latency, optional stalling ready
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt <= rsp_cnt - 1;
            if (rsp_cnt == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_word(pend_addr);
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            pend_addr <= mem_req_addr;
            rsp_cnt   <= 2;
            req_count <= req_count + 1;
        end
        mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [FW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [REG_AW-1:0] a, output logic [FW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // field i at base, junk placed in the unused half in wide mode
    task automatic put_field(input int base, input int i, input logic [15:0] v);
        int a = base + i * (cfg_wide ? 4 : 2);
        logic [15:0] j = ~v ^ 16'h5A3C;
        if (!cfg_wide) begin
            if (cfg_be) begin mem[a] = v[15:8]; mem[a+1] = v[7:0]; end
            else        begin mem[a] = v[7:0];  mem[a+1] = v[15:8]; end
        end else begin
            if (cfg_be) begin mem[a] = j[15:8]; mem[a+1] = j[7:0]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0]; end
            else        begin mem[a] = v[7:0];  mem[a+1] = v[15:8]; mem[a+2] = j[7:0]; mem[a+3] = j[15:8]; end
        end
    endtask

    task automatic put_desc(input int base, input int n, input logic [15:0] idxf,
                            input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
        put_field(base, 4*n, idxf);
        put_field(base, 4*n+1, w0);
        put_field(base, 4*n+2, w1);
        put_field(base, 4*n+3, w2);
        exp_tbl[idxf[3:0]][0] = w0;
        exp_tbl[idxf[3:0]][1] = w1;
        exp_tbl[idxf[3:0]][2] = w2;
    endtask

    task automatic start_load(input logic [31:0] p, input logic [4:0] c);
        wr(RA_PTR_LO, p[15:0]);
        wr(RA_PTR_HI, p[31:16]);
        wr(RA_COUNT, {11'h0, c});
        wr(RA_CMD, 16'h0001);
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic check_entry(input string req, input int e);
        wr(RA_SEL, 16'(e));
        for (int w = 0; w < WORDS; w++) begin
            rdreg(REG_AW'(RA_ENT0 + w), rd);
            chk(req, {16'h0, rd}, {16'h0, exp_tbl[e][w]});
        end
    endtask

    task automatic check_ptr(input string req, input logic [31:0] p);
        logic [15:0] lo, hi;
        rdreg(RA_PTR_LO, lo);
        rdreg(RA_PTR_HI, hi);
        chk(req, {hi, lo}, p);
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 req_valid", {31'h0, mem_req_valid}, 0);
        rdreg(RA_CMD, rd);  chk("R1 cmd", {16'h0, rd}, 0);
        rdreg(RA_STAT, rd); chk("R1 stat", {16'h0, rd}, 0);
        rdreg(RA_MASK, rd); chk("R1 mask", {16'h0, rd}, 0);
        wr(RA_CMD, 16'h0002);
        wr(RA_SEL, 16'd11);
        rdreg(RA_ENT1, rd); chk("R1 table word", {16'h0, rd}, 0);
        wr(RA_CMD, 16'h0000);
    endtask

    task automatic t_narrow_le();
        int r0;
        cfg_wide = 0; cfg_be = 0; stall = 1;
        put_desc(32'h100, 0, 16'hA5F2, 16'h1122, 16'h3344, 16'h5566);
        put_desc(32'h100, 1, 16'h0007, 16'hBEEF, 16'h0102, 16'hC0DE);
        put_desc(32'h100, 2, 16'hFFFF, 16'h7788, 16'h99AA, 16'hBBCC);
        put_field(32'h100, 12, 16'h8085);
        r0 = req_count;
        start_load(32'h0000_0100, 5'd3);
        wait_irq();
        chk("R8 irq after load", {31'h0, irq}, 1);
        chk("R9 request count narrow", 32'(req_count - r0), 13);
        rdreg(RA_CMD, rd);   chk("R8 load bit cleared", {16'h0, rd}, 0);
        rdreg(RA_COUNT, rd); chk("R3 count zero", {16'h0, rd}, 0);
        check_ptr("R3 ptr narrow", 32'h0000_0118);
        rdreg(RA_MASK, rd);  chk("R4 mask narrow le", {16'h0, rd}, 32'h8085);
        wr(RA_CMD, 16'h0002);
        check_entry("R2 entry 2", 2);
        check_entry("R2 entry 7", 7);
        check_entry("R6 entry 15 le", 15);
        wr(RA_CMD, 16'h0000);
        stall = 0;
    endtask

    task automatic t_readback_gate();
        wr(RA_SEL, 16'h0FF7);
        rdreg(RA_ENT0, rd); chk("R7 gated word0", {16'h0, rd}, 0);
        rdreg(RA_ENT2, rd); chk("R7 gated word2", {16'h0, rd}, 0);
        wr(RA_CMD, 16'h0002);
        rdreg(RA_ENT0, rd); chk("R7 open word0 sel high bits", {16'h0, rd}, 32'hBEEF);
        rdreg(RA_ENT2, rd); chk("R7 open word2", {16'h0, rd}, 32'hC0DE);
        wr(RA_CMD, 16'h0000);
    endtask

    task automatic t_w1c();
        wr(RA_STAT, 16'h0000);
        chk("R8 write 0 keeps flag", {31'h0, irq}, 1);
        wr(RA_STAT, 16'h0001);
        chk("R8 w1c clears irq", {31'h0, irq}, 0);
        rdreg(RA_STAT, rd); chk("R8 stat cleared", {16'h0, rd}, 0);
    endtask

    task automatic t_wide_be();
        int r0;
        cfg_wide = 1; cfg_be = 1; stall = 1;
        put_desc(32'h200, 0, 16'h0010, 16'hA1B2, 16'hC3D4, 16'hE5F6);
        put_desc(32'h200, 1, 16'h3309, 16'h0A0B, 16'h0C0D, 16'h0E0F);
        put_field(32'h200, 8, 16'hF00F);
        r0 = req_count;
        start_load(32'h0000_0200, 5'd2);
        wait_irq();
        chk("R9 request count wide", 32'(req_count - r0), 9);
        check_ptr("R3 ptr wide", 32'h0000_0220);
        rdreg(RA_MASK, rd); chk("R5 mask wide be", {16'h0, rd}, 32'hF00F);
        wr(RA_CMD, 16'h0002);
        check_entry("R5 entry 0 wide be", 0);
        check_entry("R6 entry 9 wide be", 9);
        wr(RA_CMD, 16'h0000);
        wr(RA_STAT, 16'h0001);
        stall = 0;
    endtask

    task automatic t_zero_count();
        int r0;
        cfg_wide = 1; cfg_be = 0;
        put_field(32'h280, 0, 16'h4321);
        r0 = req_count;
        start_load(32'h0000_0280, 5'd0);
        wait_irq();
        chk("R4 single request", 32'(req_count - r0), 1);
        rdreg(RA_MASK, rd); chk("R4 mask zero count wide le", {16'h0, rd}, 32'h4321);
        check_ptr("R4 ptr unchanged", 32'h0000_0280);
        wr(RA_STAT, 16'h0001);
    endtask

    task automatic t_collide();
        cfg_wide = 0; cfg_be = 1;
        put_desc(32'h300, 0, 16'h0005, 16'h2468, 16'h1357, 16'hACE0);
        put_field(32'h300, 4, 16'h1234);
        start_load(32'h0000_0300, 5'd1);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (mem_rsp_valid && pend_addr == 32'h0000_0308) begin
                reg_we = 1'b1; reg_addr = RA_STAT; reg_wdata = 16'h0001;
                @(negedge clk);
                reg_we = 1'b0;
                break;
            end
        end
        chk("R10 set wins irq", {31'h0, irq}, 1);
        rdreg(RA_STAT, rd); chk("R10 set wins stat", {16'h0, rd}, 1);
        rdreg(RA_CMD, rd);  chk("R8 load cleared at collide", {16'h0, rd}, 0);
        rdreg(RA_MASK, rd); chk("R6 mask narrow be", {16'h0, rd}, 32'h1234);
        wr(RA_CMD, 16'h0002);
        check_entry("R6 entry 5 narrow be", 5);
        wr(RA_CMD, 16'h0000);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        for (int e = 0; e < ENTRY_N; e++)
            for (int w = 0; w < WORDS; w++) exp_tbl[e][w] = 16'h0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_narrow_le();
        t_readback_gate();
        t_w1c();
        t_wide_be();
        t_zero_count();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule